// File: doc/BRIEF.md
# Two-Beat Split-Port SRAM Front End

This block puts an on-chip memory array behind two independent request ports, one for reads and one for writes. Every access moves exactly two bus-width beats. Each array word is twice the bus width, so one address selects a whole two-beat word. The address is therefore one bit shorter than a beat-level address would be. Beats are modelled as consecutive cycles of one core clock, so the block needs no dual-edge logic.

A write request carries only the address. Its two data beats follow on the next two cycles, and each beat brings its own lane-enable mask. A gathering state machine (`W_IDLE`, `W_LOW`, `W_HIGH`) holds the lower beat. When the upper beat arrives it commits both halves to the array in one operation. A read request is serialised by a second state machine (`R_IDLE`, `R_FETCH`, `R_LOW`, `R_HIGH`, `R_HIGH_FETCH`). It fetches the word once and then sends out the lower half and the upper half with a valid strobe and an echo strobe. The write machine moves `W_IDLE`→`W_LOW` on a request, `W_LOW`→`W_HIGH` unconditionally, and `W_HIGH`→`W_LOW` on a new request or →`W_IDLE` without one. The read machine moves `R_IDLE`→`R_FETCH` on a request, `R_FETCH`→`R_LOW`, `R_LOW`→`R_HIGH_FETCH` on a request or →`R_HIGH` without one, `R_HIGH_FETCH`→`R_LOW`, and `R_HIGH`→`R_FETCH` on a request or →`R_IDLE` without one.

A fetch that happens while a write to the same address is committing does not read stale data. It takes each lane from the committing write where that lane is enabled, and from the array otherwise.

Top module: `sio_b2_sram`

## Requirements
- R1: A write request accepted in cycle T takes its lower beat (`wr_data`, `wr_be`) in cycle T+1 and its upper beat in cycle T+2. The lower beat fills word bits [DW-1:0] and the upper beat fills bits [2*DW-1:DW].
- R2: Each of the 2^AW addresses holds its own 2*DW-bit word, and writes to one address leave every other address unchanged.
- R3: Lane i of a beat covers bits [9i+8:9i] and is written only when `wr_be[i]` is 1 in that beat. Both beats commit together after the upper beat. Disabled lanes keep their previous contents, and an all-zero mask leaves the word unchanged.
- R4: A read request accepted in cycle T gives the lower half in cycle T+2 and the upper half in cycle T+3. `rd_valid` is 1 in both cycles and 0 in every other cycle.
- R5: `rd_echo` is 1 with the lower beat and 0 with the upper beat. `rd_data` is all zeros whenever `rd_valid` is 0.
- R6: A read and a write may be requested in the same cycle. The read is ordered first and returns the contents from before that write.
- R7: A read requested one cycle after a write request to the same address returns the merged word: enabled lanes come from the new write and the others from the array. A read of a different address in that slot is unaffected.
- R8: Each port accepts a new request every second cycle without a pause. Requests on one port must be at least two cycles apart.
- R9: A synchronous reset abandons any write that has not yet committed and any read in flight, and forces `rd_valid` to 0. It leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one beat per cycle |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write beat data, lower then upper |
| wr_be | input | LANES | Lane enables for the current write beat |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Read beat data |
| rd_valid | output | 1 | Read beat valid |
| rd_echo | output | 1 | High on lower read beat, low on upper |

## Verification
The assertions assume that neither port issues a request in two consecutive cycles. The spacing checks report any breach, so the latency and strobe properties can rely on a request never landing in `R_FETCH` or `W_LOW`. The stimulus issues every request from one per-cycle task. Every sequence is laid out so that requests on the same port are at least two cycles apart, and it still pairs reads and writes in the same cycle and one cycle apart, so that the coherence path is exercised. Reset is raised only between whole steps.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;
    typedef enum logic [1:0] {
        W_IDLE,
        W_LOW,
        W_HIGH
    } wr_state_e;

    typedef enum logic [2:0] {
        R_IDLE,
        R_FETCH,
        R_LOW,
        R_HIGH,
        R_HIGH_FETCH
    } rd_state_e;
endpackage

// File: rtl/sio_b2_wr_gather.sv
module sio_b2_wr_gather
    import sio_b2_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int AW     = 6,
    localparam int DW    = LANE_W * LANES,
    localparam int WW    = 2 * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_req,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [LANES-1:0]   wr_be,
    output logic               commit,
    output logic [AW-1:0]      commit_addr,
    output logic [WW-1:0]      commit_word,
    output logic [2*LANES-1:0] commit_mask
);
    wr_state_e          state, nxt;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      low_q;
    logic [LANES-1:0]   low_be_q;

    always_ff @(posedge clk) begin
        if (rst) state <= W_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE:  nxt = wr_req ? W_LOW : W_IDLE;
            W_LOW:   nxt = W_HIGH;
            W_HIGH:  nxt = wr_req ? W_LOW : W_IDLE;
            default: nxt = W_IDLE;
        endcase
    end

    // Address and lower-beat holding registers need no reset.
    always_ff @(posedge clk) begin
        if (wr_req && state != W_LOW) addr_q <= wr_addr;
        if (state == W_LOW) begin
            low_q    <= wr_data;
            low_be_q <= wr_be;
        end
    end

    // Upper beat is taken straight from the port in the commit cycle.
    always_comb begin
        commit      = (state == W_HIGH) && !rst;
        commit_addr = addr_q;
        commit_word = {wr_data, low_q};
        commit_mask = {wr_be, low_be_q};
    end
endmodule

// File: rtl/sio_b2_array.sv
module sio_b2_array #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int AW     = 6,
    localparam int WLANES = 2 * LANES,
    localparam int WW     = LANE_W * WLANES,
    localparam int DEPTH  = 1 << AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WW-1:0]     wdata,
    input  logic [WLANES-1:0] wmask,
    input  logic [AW-1:0]     raddr,
    output logic [WW-1:0]     rdata
);
    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < WLANES; l++) begin
                if (wmask[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sio_b2_rd_serial.sv
module sio_b2_rd_serial
    import sio_b2_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int AW     = 6,
    localparam int DW    = LANE_W * LANES,
    localparam int WW    = 2 * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  logic [AW-1:0]      rd_addr,
    output logic [AW-1:0]      fetch_addr,
    input  logic [WW-1:0]      fetch_word,
    input  logic               byp_en,
    input  logic [AW-1:0]      byp_addr,
    input  logic [WW-1:0]      byp_word,
    input  logic [2*LANES-1:0] byp_mask,
    output logic [DW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               rd_echo
);
    rd_state_e      state, nxt;
    logic [AW-1:0]  addr_q;
    logic [WW-1:0]  word_q;
    logic [WW-1:0]  merged;
    logic           byp_hit;
    logic           take_req;
    logic           load_word;

    assign fetch_addr = addr_q;
    assign byp_hit    = byp_en && (byp_addr == addr_q);
    assign take_req   = rd_req && (state == R_IDLE || state == R_LOW || state == R_HIGH);
    assign load_word  = (state == R_FETCH) || (state == R_HIGH_FETCH);

    // Per-lane choice between the committing write and the array.
    for (genvar l = 0; l < 2 * LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = (byp_hit && byp_mask[l])
            ? byp_word[l*LANE_W +: LANE_W]
            : fetch_word[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) state <= R_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            R_IDLE:       nxt = rd_req ? R_FETCH : R_IDLE;
            R_FETCH:      nxt = R_LOW;
            R_LOW:        nxt = rd_req ? R_HIGH_FETCH : R_HIGH;
            R_HIGH:       nxt = rd_req ? R_FETCH : R_IDLE;
            R_HIGH_FETCH: nxt = R_LOW;
            default:      nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (take_req)  addr_q <= rd_addr;
        if (load_word) word_q <= merged;
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_echo  = 1'b0;
        rd_data  = '0;
        unique case (state)
            R_LOW: begin
                rd_valid = 1'b1;
                rd_echo  = 1'b1;
                rd_data  = word_q[DW-1:0];
            end
            R_HIGH, R_HIGH_FETCH: begin
                rd_valid = 1'b1;
                rd_data  = word_q[WW-1:DW];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int AW     = 6,
    localparam int DW    = LANE_W * LANES,
    localparam int WW    = 2 * DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_be,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             rd_echo
);
    logic               commit;
    logic [AW-1:0]      commit_addr;
    logic [WW-1:0]      commit_word;
    logic [2*LANES-1:0] commit_mask;
    logic [AW-1:0]      fetch_addr;
    logic [WW-1:0]      fetch_word;

    sio_b2_wr_gather #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_word (commit_word),
        .commit_mask (commit_mask)
    );

    sio_b2_array #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (commit),
        .waddr (commit_addr),
        .wdata (commit_word),
        .wmask (commit_mask),
        .raddr (fetch_addr),
        .rdata (fetch_word)
    );

    sio_b2_rd_serial #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .byp_en     (commit),
        .byp_addr   (commit_addr),
        .byp_word   (commit_word),
        .byp_mask   (commit_mask),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_echo    (rd_echo)
    );
endmodule

// File: rtl/sio_b2_sram_chk.sv
module sio_b2_sram_chk #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_req,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          rd_echo,
    input logic [DW-1:0] rd_data
);
    p_rd_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    p_wr_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req);

    p_low_beat_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> ##1 (rd_valid && rd_echo));

    p_high_beat_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> ##2 (rd_valid && !rd_echo));

    p_valid_origin_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(rd_req, 2) || $past(rd_req, 3)));

    p_echo_order_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_echo) |=> (rd_valid && !rd_echo));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> !rd_valid);
endmodule

bind sio_b2_sram sio_b2_sram_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_echo  (rd_echo),
    .rd_data  (rd_data)
);

// File: tb/test_sio_b2_sram.sv
module test_sio_b2_sram;
    localparam int AW     = 4;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int DW     = LANE_W * LANES;
    localparam int WW     = 2 * DW;
    localparam int WL     = 2 * LANES;
    localparam int NW     = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_req = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [DW-1:0]    wr_data = '0;
    logic [LANES-1:0] wr_be = '0;
    logic             rd_req = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [DW-1:0]    rd_data;
    logic             rd_valid;
    logic             rd_echo;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [WW-1:0]    model  [NW];
    logic [DW-1:0]    sch_wd [8];
    logic [LANES-1:0] sch_be [8];
    logic             exp_v  [8];
    logic [DW-1:0]    exp_d  [8];
    logic             exp_e  [8];
    string            exp_t  [8];

    always #5 clk = ~clk;

    sio_b2_sram #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) i_sio_b2_sram (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_echo(rd_echo)
    );

    function automatic logic [WW-1:0] pat(input int a, input int k);
        logic [WW-1:0] v;
        v = WW'(a * 32'h0002_F1B3 + k * 32'h0000_51D7 + 7);
        v = v ^ (WW'(k) << 21) ^ (WW'(a) << 31);
        return v;
    endfunction

    function automatic logic [WW-1:0] lane_merge(input logic [WW-1:0] old_w,
                                                 input logic [WW-1:0] new_w,
                                                 input logic [WL-1:0] m);
        logic [WW-1:0] r;
        r = old_w;
        for (int l = 0; l < WL; l++)
            if (m[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic clear_sched();
        for (int i = 0; i < 8; i++) begin
            sch_wd[i] = '0; sch_be[i] = '0; exp_v[i] = 1'b0;
            exp_d[i] = '0; exp_e[i] = 1'b0; exp_t[i] = "";
        end
    endtask

    task automatic check_slot();
        int s;
        s = cyc % 8;
        tests++;
        if (exp_v[s]) begin
            if (!(rd_valid === 1'b1 && rd_echo === exp_e[s] && rd_data === exp_d[s])) begin
                fails++;
                $display("FAIL %s cycle %0d: got v=%b e=%b d=%h expected v=1 e=%b d=%h",
                         exp_t[s], cyc, rd_valid, rd_echo, rd_data, exp_e[s], exp_d[s]);
            end
        end else if (!(rd_valid === 1'b0 && rd_data === '0)) begin
            fails++;
            $display("FAIL R5 idle cycle %0d: got v=%b d=%h expected v=0 d=0",
                     cyc, rd_valid, rd_data);
        end
        exp_v[s] = 1'b0;
    endtask

    // One cycle of stimulus; called right after a falling edge.
    task automatic step(input bit wq, input int wa, input logic [WW-1:0] ww,
                        input logic [WL-1:0] wm, input bit rq, input int ra,
                        input string tag);
        int s;
        logic [WW-1:0] w;
        s = cyc % 8;
        wr_req  = wq;
        wr_addr = AW'(wa);
        wr_data = sch_wd[s];
        wr_be   = sch_be[s];
        sch_wd[s] = '0;
        sch_be[s] = '0;
        rd_req  = rq;
        rd_addr = AW'(ra);
        if (rq) begin
            w = model[ra];
            exp_v[(cyc+2)%8] = 1'b1; exp_d[(cyc+2)%8] = w[DW-1:0];  exp_e[(cyc+2)%8] = 1'b1; exp_t[(cyc+2)%8] = tag;
            exp_v[(cyc+3)%8] = 1'b1; exp_d[(cyc+3)%8] = w[WW-1:DW]; exp_e[(cyc+3)%8] = 1'b0; exp_t[(cyc+3)%8] = tag;
        end
        if (wq) begin
            model[wa] = lane_merge(model[wa], ww, wm);
            sch_wd[(cyc+1)%8] = ww[DW-1:0];  sch_be[(cyc+1)%8] = wm[LANES-1:0];
            sch_wd[(cyc+2)%8] = ww[WW-1:DW]; sch_be[(cyc+2)%8] = wm[WL-1:LANES];
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check_slot();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, 0, "R4");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: got still running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [WW-1:0] saved;
        clear_sched();
        for (int a = 0; a < NW; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        tests++;
        if (rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset state: got v=%b expected v=0", rd_valid);
        end
        rst = 1'b0;

        // R1 R2 R8: fill every word, one write every second cycle
        for (int a = 0; a < NW; a++) begin
            step(1, a, pat(a, 1), '1, 0, 0, "R1");
            idle(1);
        end
        idle(2);
        for (int a = 0; a < NW; a++) begin
            step(0, 0, '0, '0, 1, a, "R2");
            idle(1);
        end
        idle(3);

        // R3: every lane mask, one per address
        for (int m = 0; m < (1 << WL); m++) begin
            step(1, m % NW, pat(m, 2), WL'(m), 0, 0, "R3");
            idle(1);
        end
        idle(2);
        for (int a = 0; a < NW; a++) begin
            step(0, 0, '0, '0, 1, a, "R3");
            idle(1);
        end
        idle(3);

        // R6: read and write to the same word in one cycle
        for (int a = 0; a < NW; a++) begin
            step(1, a, pat(a, 3), '1, 1, a, "R6");
            idle(1);
        end
        idle(2);
        for (int a = 0; a < NW; a++) begin
            step(0, 0, '0, '0, 1, a, "R6");
            idle(1);
        end
        idle(3);

        // R7: read lands while the write commits
        for (int m = 0; m < (1 << WL); m++) begin
            step(1, m % NW, pat(m, 4), WL'(m), 0, 0, "R7");
            step(0, 0, '0, '0, 1, m % NW, "R7");
            idle(1);
            step(0, 0, '0, '0, 1, (m + 1) % NW, "R7");
        end
        idle(4);

        // R9: reset drops a pending write and an in-flight read
        step(1, 3, pat(3, 5), '1, 0, 0, "R9");
        idle(3);
        saved = model[3];
        step(1, 3, pat(3, 6), '1, 1, 5, "R9");
        rst = 1'b1;
        clear_sched();
        model[3] = saved;
        idle(1);
        rst = 1'b0;
        idle(3);
        step(0, 0, '0, '0, 1, 3, "R9");
        idle(1);
        step(0, 0, '0, '0, 1, 5, "R9");
        idle(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule